// File: doc/BRIEF.md
# Radix-4 Booth Row Encoder

This block is the front end of a radix-4 Booth multiplier. It splits the multiplier operand into overlapping groups of three bits, with a zero placed below the least significant bit. It decodes each group into five control flags and then builds the matching partial-product row from the multiplicand. A multiplier that is `B_W` bits wide gives `B_W/2` rows. Each row is `A_W+1` bits wide, which is enough to hold twice the multiplicand.

The five flags are `neg`, `dbl`, `one`, `zero` and `cor`:
- `neg` says that the row is inverted.
- `dbl` selects twice the multiplicand.
- `one` selects the multiplicand itself.
- `zero` marks a row that contributes nothing.
- `cor` is the +1 that completes a two's-complement negation. The downstream adder tree injects it at the least significant position of the row.

An all-ones group is a "negative zero". It raises `neg` and `zero` but leaves `cor` low, so that row contributes exactly zero. Negation is an XOR of the selected bit with `neg`. A parameter can pick a multiplexer form that gives the same result. Sign extension across rows and the summation tree belong to the consumer of this block.

Top module: `booth_row_encoder`

## Requirements
- R1: Group 000 raises only `zero`. `neg`, `dbl`, `one` and `cor` are 0.
- R2: Groups 001 and 010 raise only `one`.
- R3: Group 011 raises only `dbl`.
- R4: Group 100 raises `neg`, `dbl` and `cor`. `one` and `zero` are 0.
- R5: Groups 101 and 110 raise `neg`, `one` and `cor`. `dbl` and `zero` are 0.
- R6: Group 111 raises `neg` and `zero`. `cor` is 0 and `one` and `dbl` are 0.
- R7: Row j is read as an `A_W+1`-bit two's-complement number. That value plus `cor[j]` equals k·A, where A is `a_i` read as signed and k = -2·g2 + g1 + g0 for the group {g2,g1,g0}.
- R8: Whenever `zero[j]` is 1, every bit of row j is 0, and this holds even when `neg[j]` is 1.
- R9: Row j uses the group {`b_i[2j+1]`, `b_i[2j]`, `b_i[2j-1]`}, with the bit below `b_i[0]` taken as 0. Row j occupies bits `row_o[j*(A_W+1) +: A_W+1]`, and flag bit j of each flag port belongs to row j.
- R10: For every row, exactly one of `zero`, `one` and `dbl` is 1, and `cor` equals `neg` AND NOT `zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | A_W | Multiplicand, two's complement |
| b_i | input | B_W | Multiplier, two's complement |
| row_o | output | (B_W/2)*(A_W+1) | Partial-product rows, row j at slice j |
| neg_o | output | B_W/2 | Per-row invert flag |
| dbl_o | output | B_W/2 | Per-row select-2A flag |
| one_o | output | B_W/2 | Per-row select-A flag |
| zero_o | output | B_W/2 | Per-row null-row flag |
| cor_o | output | B_W/2 | Per-row +1 correction for the next tree position |

## Verification
The embedded checks assume that both operands are two's-complement values. They also assume the inputs are stable within a time step. The block has no clock, so each check is evaluated on the settled combinational outputs, and X or Z inputs would make them meaningless. The stimulus changes the operands only at the falling edge of the bench clock, always with fully driven values. It walks every group code through every row position against extreme multiplicands (most negative, most positive, -1, 0, 1) before moving on to seeded random operands.

// File: rtl/booth_pkg.sv
package booth_pkg;

   typedef struct packed {
      logic neg;
      logic dbl;
      logic one;
      logic zero;
      logic cor;
   } booth_ctl_t;

   localparam int GROUP_W = 3;

endpackage

// File: rtl/booth_group_dec.sv
module booth_group_dec
   import booth_pkg::*;
(
   input  logic [GROUP_W-1:0] grp_i,
   output booth_ctl_t         ctl_o
);

   always_comb begin
      ctl_o = '0;
      unique case (grp_i)
         3'b000: ctl_o.zero = 1'b1;
         3'b001,
         3'b010: ctl_o.one  = 1'b1;
         3'b011: ctl_o.dbl  = 1'b1;
         3'b100: begin
            ctl_o.neg = 1'b1;
            ctl_o.dbl = 1'b1;
            ctl_o.cor = 1'b1;
         end
         3'b101,
         3'b110: begin
            ctl_o.neg = 1'b1;
            ctl_o.one = 1'b1;
            ctl_o.cor = 1'b1;
         end
         default: begin
            ctl_o.neg  = 1'b1;
            ctl_o.zero = 1'b1;
         end
      endcase
   end

   // R10: exactly one magnitude selector per group
   always_comb begin
      a_r10_one_selector: assert ($onehot({ctl_o.zero, ctl_o.one, ctl_o.dbl}))
         else $error("selector flags not one-hot for group %b", grp_i);
      a_r6_neg_zero_no_cor: assert (!(grp_i == 3'b111) || (ctl_o.zero && !ctl_o.cor))
         else $error("group 111 must give zero without correction");
   end

endmodule

// File: rtl/booth_row_gen.sv
module booth_row_gen
   import booth_pkg::*;
#(
   parameter int A_W     = 8,
   parameter bit NEG_XOR = 1'b1
) (
   input  logic [A_W-1:0] a_i,
   input  booth_ctl_t     ctl_i,
   output logic [A_W:0]   row_o
);

   localparam int RW = A_W + 1;

   // ax[k+1] = a_k (sign-extended one place), ax[0] = a_(-1) = 0
   logic [RW:0] ax;
   assign ax = {a_i[A_W-1], a_i, 1'b0};

   for (genvar k = 0; k < RW; k++) begin : g_bit
      logic sel;
      logic inv;
      assign sel = (ctl_i.one & ax[k+1]) | (ctl_i.dbl & ax[k]);
      if (NEG_XOR) begin : g_xor
         assign inv = sel ^ ctl_i.neg;
      end else begin : g_mux
         assign inv = ctl_i.neg ? ~sel : sel;
      end
      assign row_o[k] = inv & ~ctl_i.zero;
   end

   // R8: a null row is all zeros, even with the invert flag raised
   always_comb begin
      a_r8_zero_row_clear: assert (!ctl_i.zero || (row_o == '0))
         else $error("null row not cleared: %b", row_o);
   end

endmodule

// File: rtl/booth_row_encoder.sv
module booth_row_encoder
   import booth_pkg::*;
#(
   parameter int A_W     = 8,
   parameter int B_W     = 8,
   parameter bit NEG_XOR = 1'b1
) (
   input  logic [A_W-1:0]               a_i,
   input  logic [B_W-1:0]               b_i,
   output logic [(B_W/2)*(A_W+1)-1:0]   row_o,
   output logic [B_W/2-1:0]             neg_o,
   output logic [B_W/2-1:0]             dbl_o,
   output logic [B_W/2-1:0]             one_o,
   output logic [B_W/2-1:0]             zero_o,
   output logic [B_W/2-1:0]             cor_o
);

   localparam int NR = B_W / 2;
   localparam int RW = A_W + 1;

   if (B_W < 2 || (B_W % 2) != 0) begin : g_chk_b
      $error("B_W must be even and at least 2");
   end
   if (A_W < 2) begin : g_chk_a
      $error("A_W must be at least 2");
   end

   logic [B_W:0] bx;
   assign bx = {b_i, 1'b0};

   for (genvar j = 0; j < NR; j++) begin : g_row
      logic [GROUP_W-1:0] grp;
      booth_ctl_t         ctl;
      logic [RW-1:0]      row;

      assign grp = bx[2*j+2 : 2*j];

      booth_group_dec u_dec (
         .grp_i (grp),
         .ctl_o (ctl)
      );

      booth_row_gen #(
         .A_W     (A_W),
         .NEG_XOR (NEG_XOR)
      ) u_row (
         .a_i   (a_i),
         .ctl_i (ctl),
         .row_o (row)
      );

      assign row_o[j*RW +: RW] = row;
      assign neg_o[j]  = ctl.neg;
      assign dbl_o[j]  = ctl.dbl;
      assign one_o[j]  = ctl.one;
      assign zero_o[j] = ctl.zero;
      assign cor_o[j]  = ctl.cor;

      // R7: row value plus correction equals the Booth digit times A
      always_comb begin
         automatic int kd = -2 * int'(b_i[2*j+1]) + int'(bx[2*j+1]) + int'(bx[2*j]);
         automatic int rv = int'($signed(row_o[j*RW +: RW])) + int'(cor_o[j]);
         a_r7_row_value: assert (rv == kd * int'($signed(a_i)))
            else $error("row %0d value %0d, digit %0d", j, rv, kd);
         a_r10_cor_rule: assert (cor_o[j] == (neg_o[j] & ~zero_o[j]))
            else $error("row %0d correction mismatch", j);
      end
   end

endmodule

// File: tb/sim_booth_row_encoder.sv
module sim_booth_row_encoder;

   localparam int A_W = 8;
   localparam int B_W = 8;
   localparam int NR  = B_W / 2;
   localparam int RW  = A_W + 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [A_W-1:0]      a;
   logic [B_W-1:0]      b;
   logic [NR*RW-1:0]    row;
   logic [NR-1:0]       neg, dbl, one, zero, cor;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   booth_row_encoder #(.A_W(A_W), .B_W(B_W), .NEG_XOR(1'b1)) u0 (
      .a_i (a), .b_i (b), .row_o (row),
      .neg_o (neg), .dbl_o (dbl), .one_o (one), .zero_o (zero), .cor_o (cor)
   );

   // expected flags {neg,dbl,one,zero,cor} per requirement
   function automatic logic [4:0] exp_flags(input logic [2:0] g);
      case (g)
         3'b000:         return 5'b00010; // R1
         3'b001, 3'b010: return 5'b00100; // R2
         3'b011:         return 5'b01000; // R3
         3'b100:         return 5'b11001; // R4
         3'b101, 3'b110: return 5'b10101; // R5
         default:        return 5'b10010; // R6
      endcase
   endfunction

   function automatic int digit(input logic [2:0] g);
      return -2 * int'(g[2]) + int'(g[1]) + int'(g[0]);
   endfunction

   function automatic string req_of(input logic [2:0] g);
      case (g)
         3'b000:         return "R1";
         3'b001, 3'b010: return "R2";
         3'b011:         return "R3";
         3'b100:         return "R4";
         3'b101, 3'b110: return "R5";
         default:        return "R6";
      endcase
   endfunction

   task automatic check_all();
      logic [B_W:0] bx;
      bx = {b, 1'b0};
      for (int j = 0; j < NR; j++) begin
         logic [2:0]    g;
         logic [4:0]    ef, af;
         logic [RW-1:0] er, ar;
         int            ev;
         g  = bx[2*j +: 3];                 // R9 group selection
         ef = exp_flags(g);
         af = {neg[j], dbl[j], one[j], zero[j], cor[j]};
         n_vec++;
         if (af !== ef) begin
            n_fail++;
            $display("FAIL %s/R9 row %0d grp %b flags act %b exp %b", req_of(g), j, g, af, ef);
         end
         ev = digit(g) * int'($signed(a)) - int'(ef[0]);
         er = RW'(ev);
         ar = row[j*RW +: RW];
         n_vec++;
         if (ar !== er) begin
            n_fail++;
            if (ef[1])
               $display("FAIL R8 row %0d grp %b row act %b exp %b", j, g, ar, er);
            else
               $display("FAIL R7 row %0d grp %b a %0d row act %b exp %b", j, g, $signed(a), ar, er);
         end
         n_vec++;
         if ($countones({zero[j], one[j], dbl[j]}) != 1 || cor[j] !== (neg[j] & ~zero[j])) begin
            n_fail++;
            $display("FAIL R10 row %0d act %b exp one-hot selector", j, {zero[j], one[j], dbl[j]});
         end
      end
   endtask

   task automatic apply(input logic [A_W-1:0] av, input logic [B_W-1:0] bv);
      @(negedge clk);
      a = av;
      b = bv;
      #1;
      check_all();
   endtask

   initial begin
      #20000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired act hung exp finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      logic [A_W-1:0] corners [5];
      int unused_seed;
      corners[0] = 8'h80; corners[1] = 8'h7F; corners[2] = 8'hFF;
      corners[3] = 8'h00; corners[4] = 8'h01;
      a = '0;
      b = '0;
      repeat (4) @(posedge clk);
      rst = 1'b0;
      // initial state: all-zero operands give null rows (R1, R8)
      apply('0, '0);
      // directed: every group code at every row position, extreme multiplicands
      for (int j = 0; j < NR; j++) begin
         for (int g = 0; g < 8; g++) begin
            for (int c = 0; c < 5; c++) begin
               logic [B_W:0] bx;
               bx = '0;
               bx[2*j +: 3] = 3'(g);
               if (j == 0 && bx[0]) continue;  // R9: bit below b[0] is always 0
               apply(corners[c], bx[B_W:1]);
            end
         end
      end
      // all ones: every row negative zero (R6, R8)
      apply(8'h80, '1);
      apply(8'h5A, '1);
      // seeded random operands (R7)
      unused_seed = $urandom(32'h1234_5678);
      for (int i = 0; i < 3000; i++) begin
         apply(A_W'($urandom), B_W'($urandom));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule